// File: doc/BRIEF.md
# Block Copy and Search Engine

This engine walks a region of a 16-bit byte-addressed memory through a plain synchronous port (address, read data, write data, write strobe). Reads return data one cycle after the address is presented. A caller loads a source pointer, a destination pointer, a byte count and a key byte with a single start pulse, together with a two-bit operation code. The engine then runs one of four jobs: a single copy step, a copy that repeats until the count runs out, a single search step, or a search that repeats until the count runs out or the key is seen.

Every step takes two cycles: a read cycle that drives the source pointer, then an action cycle. In the action cycle a copy writes the returned byte at the destination, and a search compares that byte against the key. Copy and search share the same pointer and count sequencing. The next read comes after the previous write has landed, so a copy whose destination sits one byte above its source smears the first byte across the whole region. When the job ends, the engine raises a one-cycle done pulse. It also reports whether the count is still nonzero and whether the key was seen.

Top module: `blkmove_engine`

## Requirements
- R1: A copy step (op[0]=0) drives the source pointer with mem_we=0 in its first cycle. In its second cycle it drives the destination pointer with mem_we=1 and with mem_wdata equal to the byte read. At the end of the step both pointers have advanced by one and the count has dropped by one.
- R2: With op[1]=1 (repeat), a copy keeps stepping until the count becomes zero. It then finishes with cnt_nz=0.
- R3: A search step (op[0]=1) never asserts mem_we. It advances the source pointer by one, leaves the destination pointer unchanged and drops the count by one. found is 1 exactly when the byte read equals the key.
- R4: A repeating search stops after the first step whose byte equals the key, with found=1 and the source pointer one past the matching byte. Otherwise it stops when the count reaches zero, with found=0.
- R5: A repeating copy with destination = source + 1 fills the destination region with the byte first read from the source address.
- R6: The count is 16 bits and wraps, so a starting count of 0 with op[1]=1 runs 65536 steps. Pointers wrap from 0xFFFF to 0x0000.
- R7: start is ignored while busy is high. Values on the other inputs during a job have no effect.
- R8: busy rises in the cycle after start is sampled, and each step lasts exactly two cycles. done is a single-cycle pulse in the cycle after the last step's action cycle, with busy already low.
- R9: cnt_nz reflects a nonzero count. found is cleared on start and stays 0 for copies. A single step started with count 0 leaves the count at 0xFFFF with cnt_nz=1.
- R10: After reset the engine is idle, with busy, done, found and mem_we low and with the pointers and count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled while idle |
| op | input | 2 | bit0: 1 search / 0 copy; bit1: 1 repeat / 0 single step |
| src_init | input | 16 | Starting source pointer |
| dst_init | input | 16 | Starting destination pointer |
| cnt_init | input | 16 | Starting byte count |
| key_init | input | 8 | Byte searched for |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| cnt_nz | output | 1 | Count register is nonzero |
| found | output | 1 | Last search step matched the key |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current count |

## Verification
The hardest case to reach is the count-zero repeating search. Here both termination paths must stay quiet for 65536 steps while the pointer wraps through 0xFFFF. The bench fills memory with a pattern that never sets bit 7 and searches for 0xFF, so only the wrapped count can end the job. The overlapping fill and the early-match stop are set up by placing the destination one byte above the source, and by choosing the key equal to the pattern a few bytes into the region. A restart that is held high through a job, while the pointer inputs change, shows that mid-job launches are ignored.

// File: rtl/blk_pkg.sv
package blk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_ACT  = 2'd2
   } blk_state_e;

   typedef struct packed {
      logic rpt;
      logic cmp;
   } blk_op_t;
endpackage

// File: rtl/blk_fsm.sv
module blk_fsm
   import blk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  blk_op_t    op_q,
   input  logic       cnt_last,
   input  logic       hit,
   output blk_state_e state_q,
   output logic       load,
   output logic       step,
   output logic       done_q
);
   blk_state_e state_d;
   logic       finish;

   assign load   = (state_q == ST_IDLE) && start;
   assign step   = (state_q == ST_ACT);
   assign finish = !op_q.rpt || cnt_last || (op_q.cmp && hit);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = ST_RD;
         ST_RD:   state_d = ST_ACT;
         ST_ACT:  state_d = finish ? ST_IDLE : ST_RD;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= step && finish;
      end
   end
endmodule

// File: rtl/blk_ptrs.sv
module blk_ptrs #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              adv_dst,
   input  logic [ADDR_W-1:0] src_init,
   input  logic [ADDR_W-1:0] dst_init,
   input  logic [CNT_W-1:0]  cnt_init,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              cnt_last
);
   localparam int NPTR = 2;

   logic [ADDR_W-1:0] seed [NPTR];
   logic              adv  [NPTR];

   assign seed[0] = src_init;
   assign seed[1] = dst_init;
   assign adv[0]  = 1'b1;
   assign adv[1]  = adv_dst;

   for (genvar g = 0; g < NPTR; g++) begin : gen_ptr
      logic [ADDR_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              q <= '0;
         else if (load)           q <= seed[g];
         else if (step && adv[g]) q <= q + ADDR_W'(1);
      end
   end

   assign src_q = gen_ptr[0].q;
   assign dst_q = gen_ptr[1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= cnt_init;
      else if (step) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign cnt_last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/blk_match.sv
module blk_match #(
   parameter int DATA_W = 8,
   parameter int LANE_W = 4
) (
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] key,
   output logic              hit
);
   localparam int NLANE = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : gen_bad_lane
      $error("blk_match: DATA_W must be a multiple of LANE_W");
   end

   logic [NLANE-1:0] lane_eq;

   for (genvar l = 0; l < NLANE; l++) begin : gen_lane
      assign lane_eq[l] = (data[l*LANE_W +: LANE_W] == key[l*LANE_W +: LANE_W]);
   end

   assign hit = &lane_eq;
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
   import blk_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] src_init,
   input  logic [ADDR_W-1:0] dst_init,
   input  logic [CNT_W-1:0]  cnt_init,
   input  logic [DATA_W-1:0] key_init,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              busy,
   output logic              done,
   output logic              cnt_nz,
   output logic              found,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr,
   output logic [CNT_W-1:0]  cnt_out
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : gen_bad_addr
      $error("blkmove_engine: ADDR_W out of range");
   end
   if (CNT_W < 2) begin : gen_bad_cnt
      $error("blkmove_engine: CNT_W too small");
   end

   blk_state_e        state_q;
   blk_op_t           op_q;
   logic [DATA_W-1:0] key_q;
   logic              load, step, hit, cnt_last, found_q;

   blk_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op_q     (op_q),
      .cnt_last (cnt_last),
      .hit      (hit),
      .state_q  (state_q),
      .load     (load),
      .step     (step),
      .done_q   (done)
   );

   blk_ptrs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .adv_dst  (!op_q.cmp),
      .src_init (src_init),
      .dst_init (dst_init),
      .cnt_init (cnt_init),
      .src_q    (src_ptr),
      .dst_q    (dst_ptr),
      .cnt_q    (cnt_out),
      .cnt_last (cnt_last)
   );

   blk_match #(.DATA_W(DATA_W)) u_match (
      .data (mem_rdata),
      .key  (key_q),
      .hit  (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= '0;
         key_q   <= '0;
         found_q <= 1'b0;
      end else if (load) begin
         op_q    <= blk_op_t'(op);
         key_q   <= key_init;
         found_q <= 1'b0;
      end else if (step && op_q.cmp) begin
         found_q <= hit;
      end
   end

   assign mem_we    = step && !op_q.cmp;
   assign mem_addr  = mem_we ? dst_ptr : src_ptr;
   assign mem_wdata = mem_rdata;
   assign busy      = (state_q != ST_IDLE);
   assign cnt_nz    = (cnt_out != '0);
   assign found     = found_q;
endmodule

// File: rtl/blkmove_engine_chk.sv
module blkmove_engine_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              found,
   input logic              mem_we,
   input logic [1:0]        op_q,
   input logic [ADDR_W-1:0] dst_ptr,
   input logic [CNT_W-1:0]  cnt_out
);
   assert_write_adv_dst_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (dst_ptr == $past(dst_ptr) + ADDR_W'(1)));

   assert_search_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q[0]) |-> !mem_we);

   assert_match_ends_job_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(found) |-> (done && !busy));

   assert_cnt_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && (cnt_out != $past(cnt_out))) |-> (cnt_out == $past(cnt_out) - CNT_W'(1)));

   assert_op_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(op_q));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind blkmove_engine blkmove_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .found   (found),
   .mem_we  (mem_we),
   .op_q    (op_q),
   .dst_ptr (dst_ptr),
   .cnt_out (cnt_out)
);

// File: tb/blkmove_engine_test.sv
module blkmove_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
   logic [7:0]  key_init = '0;
   logic [15:0] mem_addr, src_ptr, dst_ptr, cnt_out;
   logic [7:0]  mem_rdata = '0, mem_wdata;
   logic        mem_we, busy, done, cnt_nz, found;

   int errs = 0;
   int checks = 0;

   logic [7:0] dmem [int];
   logic [7:0] rmem [int];

   always #4 clk = ~clk;

   blkmove_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init), .key_init(key_init),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .busy(busy), .done(done), .cnt_nz(cnt_nz), .found(found),
      .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt_out(cnt_out)
   );

   function automatic logic [7:0] init_b(int a);
      return 8'((a ^ (a >> 8)) & 'h7F);
   endfunction
   function automatic logic [7:0] rd_d(int a);
      return dmem.exists(a) ? dmem[a] : init_b(a);
   endfunction
   function automatic logic [7:0] rd_r(int a);
      return rmem.exists(a) ? rmem[a] : init_b(a);
   endfunction

   always @(posedge clk) begin
      mem_rdata <= rd_d(int'(mem_addr));
      if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL R8 watchdog: actual hung expected done");
      summary();
   end

   // Runs one job against the reference model, comparing every cycle.
   task automatic run(string tag, logic [1:0] o, logic [15:0] s, logic [15:0] d,
                      logic [15:0] c, logic [7:0] k, bit hold);
      logic [15:0] ms, md, mc;
      logic [7:0]  b;
      logic        mf;
      bit          last;
      @(negedge clk);
      op = o; src_init = s; dst_init = d; cnt_init = c; key_init = k; start = 1'b1;
      @(posedge clk);
      ms = s; md = d; mc = c; mf = 1'b0;
      forever begin
         @(negedge clk);
         if (hold) begin
            src_init = 16'hDEAD; dst_init = 16'hBEEF; cnt_init = 16'd1; op = ~o;
         end else start = 1'b0;
         chk(tag, "busy rd", busy, 1);
         chk("R8", "done rd", done, 0);
         chk(tag, "addr rd", mem_addr, ms);
         chk(tag, "we rd", mem_we, 0);
         chk(tag, "src rd", src_ptr, ms);
         chk(tag, "cnt rd", cnt_out, mc);
         @(posedge clk);
         @(negedge clk);
         b = rd_r(int'(ms));
         chk("R8", "busy act", busy, 1);
         chk(o[0] ? "R3" : "R1", "we act", mem_we, !o[0]);
         if (!o[0]) begin
            chk("R1", "addr act", mem_addr, md);
            chk("R1", "wdata act", mem_wdata, b);
         end
         @(posedge clk);
         if (!o[0]) rmem[int'(md)] = b;
         mf = o[0] && (b == k);
         ms = ms + 16'd1;
         if (!o[0]) md = md + 16'd1;
         mc = mc - 16'd1;
         last = !o[1] || (mc == 0) || mf;
         if (last) break;
      end
      @(negedge clk);
      start = 1'b0;
      chk("R8", "done end", done, 1);
      chk("R8", "busy end", busy, 0);
      chk(tag, "src end", src_ptr, ms);
      chk(tag, "dst end", dst_ptr, md);
      chk(tag, "cnt end", cnt_out, mc);
      chk("R9", "found end", found, mf);
      chk("R9", "cnt_nz end", cnt_nz, mc != 0);
      @(negedge clk);
      chk("R8", "done pulse", done, 0);
   endtask

   task automatic mem_cmp(string tag, logic [15:0] base, int n);
      for (int i = 0; i < n; i++) begin
         logic [15:0] a;
         a = base + 16'(i);
         chk(tag, "mem", rd_d(int'(a)), rd_r(int'(a)));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", "busy", busy, 0);
      chk("R10", "done", done, 0);
      chk("R10", "found", found, 0);
      chk("R10", "we", mem_we, 0);
      chk("R10", "src", src_ptr, 0);
      chk("R10", "cnt", cnt_out, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 single copy
      run("R1", 2'b00, 16'h1000, 16'h2000, 16'd5, 8'h00, 0);
      mem_cmp("R1", 16'h2000, 2);
      // R2 repeating copy
      run("R2", 2'b10, 16'h1100, 16'h3000, 16'd6, 8'h00, 0);
      mem_cmp("R2", 16'h3000, 8);
      // R5 overlapping fill
      run("R5", 2'b10, 16'h4000, 16'h4001, 16'd8, 8'h00, 0);
      for (int i = 0; i < 9; i++)
         chk("R5", "fill byte", rd_d(16'h4000 + i), init_b(16'h4000));
      // R3 single search, hit and miss
      run("R3", 2'b01, 16'h1234, 16'h0777, 16'd3, init_b(16'h1234), 0);
      chk("R3", "found hit", found, 1);
      run("R3", 2'b01, 16'h1234, 16'h0777, 16'd3, 8'h7E ^ init_b(16'h1234), 0);
      chk("R3", "found miss", found, 0);
      // R4 repeating search: early match, then count-out
      run("R4", 2'b11, 16'h0500, 16'h0000, 16'd10, init_b(16'h0503), 0);
      chk("R4", "src past match", src_ptr, 16'h0504);
      run("R4", 2'b11, 16'h0600, 16'h0000, 16'd5, 8'hFF, 0);
      chk("R4", "count-out found", found, 0);
      // R6 pointer wrap
      run("R6", 2'b10, 16'hFFFE, 16'hFFFD, 16'd4, 8'h00, 0);
      mem_cmp("R6", 16'hFFFD, 5);
      // R7 start held high with changing inputs during a job
      run("R7", 2'b10, 16'h2200, 16'h5000, 16'd3, 8'h00, 1);
      mem_cmp("R7", 16'h5000, 4);
      // R9 single step from count zero
      run("R9", 2'b00, 16'h0100, 16'h6000, 16'd0, 8'h00, 0);
      chk("R9", "cnt wrap", cnt_out, 16'hFFFF);
      // R6 full 65536-step search
      run("R6", 2'b11, 16'h8000, 16'h0000, 16'd0, 8'hFF, 0);
      chk("R6", "src full wrap", src_ptr, 16'h8000);
      summary();
   end
endmodule